// File: doc/BRIEF.md
# Activity-Adaptive Scan Shift Rate Controller

This block paces scan loading under a peak power budget. Every load starts at the slowest shift rate. A power budget sized for a chain full of toggling bits allows that rate. As the load goes on, the block watches the bit that enters each scan chain. A cycle where the incoming bit equals the bit already held in the first flop of a chain causes no transition down that chain. The block counts these quiet entries. Each time the count reaches a fixed threshold, it clears the count and shortens the shift period by one reference clock cycle. It keeps doing this until the period is a single reference cycle.

The block does not gate the clock. It outputs a one-cycle shift strobe, `shift_en`, on the fast reference clock, and the scan flops use it as their enable. It also outputs the current speed step. The threshold is the total scan flop count divided by the number of speed steps. The step count must be a power of two.

An optional external mode ignores the chain monitors. In that mode the step advances on a speed-up request that is held high during a shift strobe.

Top module: `scan_rate_ctrl`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls with `scan_en` low, `step_idx` is 0 and `shift_en` is 0.
- R2: At step index s (0 = slowest, NUM_STEPS-1 = fastest), `shift_en` pulses once every NUM_STEPS-s reference cycles. The first pulse comes NUM_STEPS cycles after the cycle in which a rising edge of `scan_en` is seen.
- R3: In counting mode (`ext_mode` = 0), chain k is quiet in a strobe cycle when `chain_si[k]` equals `chain_q0[k]`. Only strobe cycles are counted.
- R4: In one strobe cycle the counter adds the number of quiet chains, from 0 to NUM_CHAINS.
- R5: When the running count plus the new quiet chains reaches TOTAL_FLOPS/NUM_STEPS, the count is cleared and any excess is dropped. `step_idx` then rises by exactly one. The new period applies from the next interval; the strobe that crosses the threshold ends the interval at the old period.
- R6: `step_idx` saturates at NUM_STEPS-1. At that step `shift_en` is high in every cycle while `scan_en` is high, through the undivided bypass path.
- R7: A rising edge of `scan_en` returns the step, the counter and the divider to their start values. No strobe is issued in the edge cycle.
- R8: Between rising edges of `scan_en`, `step_idx` never decreases.
- R9: While `scan_en` is low, `shift_en` stays 0 and `step_idx` holds.
- R10: With `ext_mode` = 1, the step advances by one at each strobe where `speed_up` is high. `speed_up` outside strobe cycles and all chain inputs have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Fast reference clock |
| rst | input | 1 | Synchronous active-high reset |
| scan_en | input | 1 | Scan enable; its rising edge starts a load |
| ext_mode | input | 1 | 1 = step requests come from `speed_up`; 0 = on-chip counting |
| speed_up | input | 1 | External step-advance request, sampled in strobe cycles |
| chain_si | input | NUM_CHAINS | Serial input bit of each chain |
| chain_q0 | input | NUM_CHAINS | Output of the first flop of each chain |
| shift_en | output | 1 | One-cycle shift strobe for the scan flops |
| step_idx | output | $clog2(NUM_STEPS) | Current speed step, 0 = slowest |

## Verification
Two things can land on the same strobe: a threshold crossing and the end of a period. The crossing can also coincide with saturation at the fastest step, or with a count that overshoots the threshold when several chains are quiet at once. Fully quiet streams, chain-by-chain mixes and a pseudo-random stream drive these cases on a two-chain, four-step configuration. For each strobe, the bench checks the interval before it against the step that held during that interval, not the step that follows it. A second collision occurs when `scan_en` rises again while the block runs at a high step. The bench checks that the edge cycle carries no strobe and that the next interval has the full slowest length.

// File: rtl/scr_pkg.sv
package scr_pkg;

    // Source of step-advance requests.
    typedef enum logic {
        SRC_COUNTER  = 1'b0,
        SRC_EXTERNAL = 1'b1
    } adv_src_e;

    // Per-cycle control pair shared between the pacing pieces.
    typedef struct packed {
        logic restart;   // rising edge of scan enable seen this cycle
        logic strobe;    // shift happens at the coming edge
    } pace_ctl_t;

    // A period counter of log2(v) bits only wraps cleanly for powers of two.
    function automatic bit is_pow2(input int unsigned v);
        return (v >= 2) && ((v & (v - 1)) == 0);
    endfunction

endpackage

// File: rtl/scr_activity.sv
module scr_activity #(
    parameter int NUM_CHAINS = 4,
    localparam int ADD_W = $clog2(NUM_CHAINS + 1)
) (
    input  logic                  count_on,
    input  logic [NUM_CHAINS-1:0] chain_si,
    input  logic [NUM_CHAINS-1:0] chain_q0,
    output logic [ADD_W-1:0]      quiet_cnt
);

    logic [NUM_CHAINS-1:0] quiet;

    // R3: one equality detector per chain.
    for (genvar g = 0; g < NUM_CHAINS; g++) begin : g_det
        assign quiet[g] = ~(chain_si[g] ^ chain_q0[g]);
    end

    // R4: parallel count of quiet chains.
    always_comb begin
        quiet_cnt = '0;
        if (count_on) begin
            for (int k = 0; k < NUM_CHAINS; k++) begin
                quiet_cnt = quiet_cnt + ADD_W'(quiet[k]);
            end
        end
    end

endmodule

// File: rtl/scr_step_ctrl.sv
module scr_step_ctrl
    import scr_pkg::*;
#(
    parameter int NUM_CHAINS = 4,
    parameter int NUM_STEPS  = 8,
    parameter int THRESH     = 125,
    localparam int ADD_W  = $clog2(NUM_CHAINS + 1),
    localparam int STEP_W = $clog2(NUM_STEPS),
    localparam int CNT_W  = $clog2(THRESH + NUM_CHAINS + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  pace_ctl_t         ctl,
    input  adv_src_e          src,
    input  logic              speed_up,
    input  logic [ADD_W-1:0]  quiet_cnt,
    output logic [STEP_W-1:0] step_q,
    output logic              at_fastest
);

    localparam logic [STEP_W-1:0] TOP_STEP  = STEP_W'(NUM_STEPS - 1);
    localparam logic [CNT_W-1:0]  THRESH_CW = CNT_W'(THRESH);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] sum;
    logic             advance;

    assign at_fastest = (step_q == TOP_STEP);
    assign sum        = cnt_q + CNT_W'(quiet_cnt);

    always_comb begin
        advance = 1'b0;
        if (ctl.strobe) begin
            if (src == SRC_EXTERNAL) advance = speed_up;
            else                     advance = (sum >= THRESH_CW);
        end
    end

    always_ff @(posedge clk) begin
        if (rst || ctl.restart) begin
            cnt_q  <= '0;
            step_q <= '0;
        end else if (ctl.strobe) begin
            if (src == SRC_EXTERNAL || advance) cnt_q <= '0;
            else                                cnt_q <= sum;
            if (advance && !at_fastest) step_q <= step_q + STEP_W'(1);
        end
    end

    // R5: count stays below the threshold between strobes.
    p_cnt_below_thresh_r5: assert property (@(posedge clk) disable iff (rst)
        cnt_q < THRESH_CW);

    // R5: a step moves only after a strobe from the rate generator.
    p_step_on_strobe_r5: assert property (@(posedge clk) disable iff (rst)
        (!ctl.restart && !ctl.strobe) |=> $stable(step_q));

    // R5: a step moves by at most one per strobe.
    p_step_by_one_r5: assert property (@(posedge clk) disable iff (rst)
        !ctl.restart |=> (step_q == $past(step_q)) || (step_q == $past(step_q) + STEP_W'(1)));

    // R8: no decrease within a load.
    p_step_monotonic_r8: assert property (@(posedge clk) disable iff (rst)
        !ctl.restart |=> step_q >= $past(step_q));

    // R7: an edge of scan enable restarts at the slowest step.
    p_restart_slowest_r7: assert property (@(posedge clk) disable iff (rst)
        ctl.restart |=> step_q == '0);

endmodule

// File: rtl/scr_rate_gen.sv
module scr_rate_gen #(
    parameter int NUM_STEPS = 8,
    localparam int STEP_W = $clog2(NUM_STEPS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              restart,
    input  logic              scan_en,
    input  logic [STEP_W-1:0] step,
    input  logic              at_fastest,
    output logic              shift_en
);

    localparam logic [STEP_W-1:0] TOP_STEP = STEP_W'(NUM_STEPS - 1);

    logic [STEP_W-1:0] div_q;
    logic [STEP_W-1:0] last_tick;
    logic              div_tick;
    logic              tick;

    // Period is NUM_STEPS - step reference cycles; the last count value is one less.
    assign last_tick = TOP_STEP - step;
    assign div_tick  = (div_q == last_tick);
    // R6: fastest step takes the undivided path.
    assign tick      = at_fastest ? 1'b1 : div_tick;
    assign shift_en  = scan_en & ~restart & tick;

    always_ff @(posedge clk) begin
        if (rst || restart) div_q <= '0;
        else if (scan_en) begin
            if (shift_en) div_q <= '0;
            else          div_q <= div_q + STEP_W'(1);
        end
    end

    // R2: the divider never runs past the end of the current period.
    p_div_in_period_r2: assert property (@(posedge clk) disable iff (rst)
        div_q <= last_tick);

endmodule

// File: rtl/scan_rate_ctrl.sv
module scan_rate_ctrl
    import scr_pkg::*;
#(
    parameter int NUM_CHAINS  = 4,
    parameter int NUM_STEPS   = 8,
    parameter int TOTAL_FLOPS = 1000,
    localparam int STEP_W = $clog2(NUM_STEPS),
    localparam int ADD_W  = $clog2(NUM_CHAINS + 1),
    localparam int THRESH = TOTAL_FLOPS / NUM_STEPS
) (
    input  logic                  clk_ref,
    input  logic                  rst,
    input  logic                  scan_en,
    input  logic                  ext_mode,
    input  logic                  speed_up,
    input  logic [NUM_CHAINS-1:0] chain_si,
    input  logic [NUM_CHAINS-1:0] chain_q0,
    output logic                  shift_en,
    output logic [STEP_W-1:0]     step_idx
);

    initial begin
        a_cfg_steps: assert (is_pow2(NUM_STEPS));
        a_cfg_thresh: assert (THRESH >= 1);
    end

    logic             se_q;
    pace_ctl_t        ctl;
    adv_src_e         src;
    logic [ADD_W-1:0] quiet_cnt;
    logic             at_fastest;

    always_ff @(posedge clk_ref) begin
        if (rst) se_q <= 1'b0;
        else     se_q <= scan_en;
    end

    assign src         = adv_src_e'(ext_mode);
    assign ctl.restart = scan_en & ~se_q;
    assign ctl.strobe  = shift_en;

    scr_activity #(
        .NUM_CHAINS(NUM_CHAINS)
    ) u_activity (
        .count_on (src == SRC_COUNTER),
        .chain_si (chain_si),
        .chain_q0 (chain_q0),
        .quiet_cnt(quiet_cnt)
    );

    scr_step_ctrl #(
        .NUM_CHAINS(NUM_CHAINS),
        .NUM_STEPS (NUM_STEPS),
        .THRESH    (THRESH)
    ) u_step (
        .clk       (clk_ref),
        .rst       (rst),
        .ctl       (ctl),
        .src       (src),
        .speed_up  (speed_up),
        .quiet_cnt (quiet_cnt),
        .step_q    (step_idx),
        .at_fastest(at_fastest)
    );

    scr_rate_gen #(
        .NUM_STEPS(NUM_STEPS)
    ) u_rate (
        .clk       (clk_ref),
        .rst       (rst),
        .restart   (ctl.restart),
        .scan_en   (scan_en),
        .step      (step_idx),
        .at_fastest(at_fastest),
        .shift_en  (shift_en)
    );

    // R9: an idle scan enable leaves the step alone.
    p_idle_hold_r9: assert property (@(posedge clk_ref) disable iff (rst)
        !scan_en |=> $stable(step_idx));

    // R6: at the fastest step every active non-edge cycle shifts.
    p_fast_every_cycle_r6: assert property (@(posedge clk_ref) disable iff (rst)
        (scan_en && se_q && at_fastest) |-> shift_en);

endmodule

// File: tb/scan_rate_ctrl_test.sv
`timescale 1ns/1ps
module scan_rate_ctrl_test;

    localparam int NC = 2;
    localparam int V  = 4;
    localparam int NF = 12;
    localparam int TH = NF / V;
    localparam int SW = $clog2(V);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          scan_en = 1'b0;
    logic          ext_mode = 1'b0;
    logic          speed_up = 1'b0;
    logic [NC-1:0] chain_si = '0;
    logic [NC-1:0] chain_q0 = '0;
    logic          shift_en;
    logic [SW-1:0] step_idx;

    int checks = 0;
    int errors = 0;

    // bench-side model state
    logic [NC-1:0] ff = '0;
    logic          prev_se = 1'b0;
    int            gap = 0;
    int            m_step = 0;
    int            m_cnt = 0;

    always #2.5 clk = ~clk;

    scan_rate_ctrl #(
        .NUM_CHAINS (NC),
        .NUM_STEPS  (V),
        .TOTAL_FLOPS(NF)
    ) uut (
        .clk_ref (clk),
        .rst     (rst),
        .scan_en (scan_en),
        .ext_mode(ext_mode),
        .speed_up(speed_up),
        .chain_si(chain_si),
        .chain_q0(chain_q0),
        .shift_en(shift_en),
        .step_idx(step_idx)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // One reference cycle: drive at the falling edge, sample 1 ns later.
    task automatic run(input logic se, input logic [NC-1:0] si_v, input logic su, input string tag);
        logic rise;
        logic exp_sh;
        int   add;
        @(negedge clk);
        scan_en  = se;
        chain_si = si_v;
        speed_up = su;
        chain_q0 = ff;
        #1;
        check({tag, " R8 step"}, int'(step_idx), m_step);
        rise   = se && !prev_se;
        exp_sh = 1'b0;
        if (rise) begin
            gap = 0; m_step = 0; m_cnt = 0;   // R7
        end else if (se) begin
            gap++;
            exp_sh = (gap == V - m_step);     // R2
        end
        check({tag, " R2 strobe"}, int'(shift_en), int'(exp_sh));
        if (exp_sh) begin
            gap = 0;
            if (ext_mode) begin               // R10
                if (su && m_step < V - 1) m_step++;
                m_cnt = 0;
            end else begin                    // R3 R4 R5 R6
                add = 0;
                for (int k = 0; k < NC; k++) if (si_v[k] == ff[k]) add++;
                if (m_cnt + add >= TH) begin
                    m_cnt = 0;
                    if (m_step < V - 1) m_step++;
                end else m_cnt = m_cnt + add;
            end
            ff = si_v;
        end
        prev_se = se;
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog expired actual 0 expected 1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] lf;
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 step in reset", int'(step_idx), 0);
        check("R1 strobe in reset", int'(shift_en), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 step after reset", int'(step_idx), 0);
        check("R1 strobe after reset", int'(shift_en), 0);

        // R6: all-ones stream climbs through every step and saturates
        ff = 2'b01;
        for (int c = 0; c < 60; c++) run(1'b1, 2'b11, 1'b0, "R6 ones");
        check("R6 saturated step", int'(step_idx), V - 1);

        // R9: idle scan enable, then R7 restart from a high step
        for (int c = 0; c < 4; c++) run(1'b0, 2'b00, 1'b0, "R9 idle");
        ff = 2'b01;
        for (int c = 0; c < 30; c++) run(1'b1, ~ff, 1'b0, "R7 alternating");
        check("R3 alternating stays slow", int'(step_idx), 0);
        for (int c = 0; c < 2; c++) run(1'b0, 2'b00, 1'b0, "R9 idle");

        // R4: one quiet chain per strobe
        ff = 2'b10;
        for (int c = 0; c < 70; c++) run(1'b1, {ff[1], ~ff[0]}, 1'b0, "R4 one quiet");
        run(1'b0, 2'b00, 1'b0, "R9 idle");

        // R5: overshoot and crossing mixes from a pseudo-random stream
        lf = 8'h5A;
        ff = 2'b01;
        for (int c = 0; c < 200; c++) begin
            lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
            run(1'b1, lf[1:0], 1'b0, "R5 mixed");
            if (c == 120) run(1'b0, 2'b00, 1'b0, "R7 mid drop");
        end
        run(1'b0, 2'b00, 1'b0, "R9 idle");

        // R10: external requests; chains quiet but ignored
        ext_mode = 1'b1;
        ff = 2'b11;
        for (int c = 0; c < 20; c++) run(1'b1, 2'b11, 1'b0, "R10 no request");
        check("R10 chains ignored", int'(step_idx), 0);
        for (int c = 0; c < 20; c++) run(1'b1, 2'b11, logic'(c % 3 == 0), "R10 sparse request");
        for (int c = 0; c < 20; c++) run(1'b1, 2'b00, 1'b1, "R10 held request");
        check("R10 saturated", int'(step_idx), V - 1);
        run(1'b0, 2'b00, 1'b0, "R9 idle");
        ext_mode = 1'b0;

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule